// File: doc/BRIEF.md
# Serial Configuration Register Loader

This block is the programming port of a receive mixer with an on-chip frequency synthesizer. A host drives three wires: a serial clock, a serial data line and a load strobe. Data bits move into a 24-bit shift register on each rising edge of the serial clock, most significant bit first. When the load strobe rises, the whole 24-bit word is copied into one of eight configuration registers. The three lowest bits of that word select the register. The stored word keeps those address bits.

All three wires, and the two mode pins, come from outside the chip and are asynchronous. Each one goes through a two-flop synchronizer into a faster system clock, and an edge detector follows. Every register update therefore happens in one clock domain. The serial clock can run at up to 20 MHz, with each phase at least 25 ns long. For that reason the system clock must give at least two samples per serial clock phase.

The block also decodes a few fields from the stored registers:
- The charge-pump current select and the reference-current source, both from register 4.
- The oscillator mode. A synthesizer-enable pin is combined with a synthesizer-enable bit in register 5. The result selects either the internal synthesizer or an externally applied local oscillator.
- The direction of the oscillator pins. A driver-enable pin is combined with a driver-enable bit in register 5 to decide whether the pins act as inputs or outputs.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset all eight registers hold zero, `synth_active_o` is 0, `lo_pins_out_o` is 0 and `ext_lo_sel_o` is 1.
- R2: Each rising edge of `ser_clk_i` shifts `ser_data_i` into bit 0 of the 24-bit shift register, and every other bit moves one place toward bit 23. A word is therefore sent most significant bit first.
- R3: A rising edge of `ser_load_i` copies the full 24-bit shift word into register N, where N is the value of word bits 2:0. Register N occupies bits N*24+23 down to N*24 of `cfg_regs_o`.
- R4: A load changes only the selected register. The other seven keep their contents.
- R5: No register changes without a rising edge of `ser_load_i`. This holds while serial clocks arrive and while `ser_load_i` stays high.
- R6: When more than 24 bits are clocked in before a load, only the last 24 bits are kept.
- R7: `pump_sel_o` equals register 4 bits 11:10. Codes 0, 1, 2 and 3 select 250 µA, 500 µA, 750 µA and 1 mA. `ref_ext_o` equals register 4 bit 18, where 0 means internal and 1 means external reference current.
- R8: `synth_active_o` is 1 only when `synth_en_pin_i` is high and register 5 bit 6 is 1. `ext_lo_sel_o` is always the inverse of `synth_active_o`.
- R9: `lo_pins_out_o` is 1 only when `synth_active_o` is 1 and either `lo_drv_pin_i` is high or register 5 bit 3 is 1. Otherwise the oscillator pins are inputs.
- R10: Take the system clock edges that follow a change on `ser_load_i`. After the second of these edges, the register still holds its old value. After the third edge, it holds the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock, asynchronous |
| ser_data_i | input | 1 | Serial data, asynchronous |
| ser_load_i | input | 1 | Load strobe. Its rising edge commits the word |
| synth_en_pin_i | input | 1 | Synthesizer enable pin |
| lo_drv_pin_i | input | 1 | Oscillator driver enable pin |
| cfg_regs_o | output | 192 | Eight 24-bit registers, register 0 in the low bits |
| pump_sel_o | output | 2 | Charge-pump current code |
| ref_ext_o | output | 1 | Reference current source, 1 = external |
| synth_active_o | output | 1 | Internal synthesizer in use |
| ext_lo_sel_o | output | 1 | External oscillator routed to the mixer |
| lo_pins_out_o | output | 1 | Oscillator pins driven as outputs |

## Verification
The assertions check several properties on every cycle:
- The registers are zero when reset is released.
- No register moves except on a detected load edge.
- A load touches no register other than the one its address bits select.
- The shift register takes exactly one new bit per detected serial clock edge.
- The oscillator pins are driven only while the synthesizer is active, and the synthesizer is active only when its register bit is set.

Some behaviours can only be shown by the bench's scenarios:
- That the correct word lands in each register over a full serial transfer.
- That extra leading bits are dropped.
- The exact three-edge latency of a load.
- The full truth table that combines the two pins with the two register-5 bits.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
    localparam int unsigned CFG_WORD_W   = 24;
    localparam int unsigned CFG_ADDR_W   = 3;
    localparam int unsigned CFG_SYNC_N   = 2;
    localparam int unsigned PUMP_REG     = 4;
    localparam int unsigned PUMP_LSB     = 10;
    localparam int unsigned REFSRC_BIT   = 18;
    localparam int unsigned MODE_REG     = 5;
    localparam int unsigned SYN_EN_BIT   = 6;
    localparam int unsigned DRV_EN_BIT   = 3;

    // index of each asynchronous input inside the synchronizer vector
    typedef enum int unsigned {
        IN_SCLK = 0,
        IN_SDAT = 1,
        IN_LOAD = 2,
        IN_SYN  = 3,
        IN_DRV  = 4
    } in_idx_e;
    localparam int unsigned IN_COUNT = 5;
endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic [W-1:0]             prev;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.pipe[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            st_d.pipe[s] = st_q.pipe[s-1];
        end
        st_d.prev    = st_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.pipe[STAGES-1];
    assign rise_o  = st_q.pipe[STAGES-1] & ~st_q.prev;
endmodule

// File: rtl/ser_cfg_shift.sv
module ser_cfg_shift #(
    parameter int unsigned WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              bit_i,
    output logic [WORD_W-1:0] word_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step_i) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_o = st_q.sr;
endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank #(
    parameter int unsigned WORD_W = 24,
    parameter int unsigned ADDR_W = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              commit_i,
    input  logic [WORD_W-1:0]                 word_i,
    output logic [(WORD_W<<ADDR_W)-1:0]       regs_o
);
    localparam int unsigned NREG = 1 << ADDR_W;

    logic [ADDR_W-1:0] sel;
    assign sel = word_i[ADDR_W-1:0];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [WORD_W-1:0] val_d, val_q;

        always_comb begin
            val_d = val_q;
            if (commit_i && (sel == ADDR_W'(g))) begin
                val_d = word_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= '0;
            else        val_q <= val_d;
        end

        assign regs_o[g*WORD_W +: WORD_W] = val_q;
    end
endmodule

// File: rtl/ser_cfg_mode.sv
module ser_cfg_mode #(
    parameter int unsigned WORD_W     = 24,
    parameter int unsigned PUMP_LSB   = 10,
    parameter int unsigned REFSRC_BIT = 18,
    parameter int unsigned SYN_EN_BIT = 6,
    parameter int unsigned DRV_EN_BIT = 3
) (
    input  logic [WORD_W-1:0] pump_reg_i,
    input  logic [WORD_W-1:0] mode_reg_i,
    input  logic              syn_pin_i,
    input  logic              drv_pin_i,
    output logic [1:0]        pump_sel_o,
    output logic              ref_ext_o,
    output logic              synth_active_o,
    output logic              ext_lo_sel_o,
    output logic              lo_pins_out_o
);
    logic active;

    always_comb begin
        pump_sel_o     = pump_reg_i[PUMP_LSB +: 2];
        ref_ext_o      = pump_reg_i[REFSRC_BIT];
        active         = syn_pin_i & mode_reg_i[SYN_EN_BIT];
        synth_active_o = active;
        ext_lo_sel_o   = ~active;
        lo_pins_out_o  = active & (drv_pin_i | mode_reg_i[DRV_EN_BIT]);
    end
endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import ser_cfg_pkg::*;
#(
    parameter int unsigned WORD_W = CFG_WORD_W,
    parameter int unsigned ADDR_W = CFG_ADDR_W,
    parameter int unsigned SYNC_N = CFG_SYNC_N
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ser_clk_i,
    input  logic                        ser_data_i,
    input  logic                        ser_load_i,
    input  logic                        synth_en_pin_i,
    input  logic                        lo_drv_pin_i,
    output logic [(WORD_W<<ADDR_W)-1:0] cfg_regs_o,
    output logic [1:0]                  pump_sel_o,
    output logic                        ref_ext_o,
    output logic                        synth_active_o,
    output logic                        ext_lo_sel_o,
    output logic                        lo_pins_out_o
);
    logic [IN_COUNT-1:0] raw_in, lvl, rise;
    logic [WORD_W-1:0]   shift_word;
    logic                sclk_step;
    logic                load_commit;

    assign raw_in[IN_SCLK] = ser_clk_i;
    assign raw_in[IN_SDAT] = ser_data_i;
    assign raw_in[IN_LOAD] = ser_load_i;
    assign raw_in[IN_SYN]  = synth_en_pin_i;
    assign raw_in[IN_DRV]  = lo_drv_pin_i;

    ser_cfg_sync #(.W(IN_COUNT), .STAGES(SYNC_N)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .level_o (lvl),
        .rise_o  (rise)
    );

    assign sclk_step   = rise[IN_SCLK];
    assign load_commit = rise[IN_LOAD];

    ser_cfg_shift #(.WORD_W(WORD_W)) i_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .step_i (sclk_step),
        .bit_i  (lvl[IN_SDAT]),
        .word_o (shift_word)
    );

    ser_cfg_bank #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (load_commit),
        .word_i   (shift_word),
        .regs_o   (cfg_regs_o)
    );

    ser_cfg_mode #(
        .WORD_W     (WORD_W),
        .PUMP_LSB   (PUMP_LSB),
        .REFSRC_BIT (REFSRC_BIT),
        .SYN_EN_BIT (SYN_EN_BIT),
        .DRV_EN_BIT (DRV_EN_BIT)
    ) i_mode (
        .pump_reg_i     (cfg_regs_o[PUMP_REG*WORD_W +: WORD_W]),
        .mode_reg_i     (cfg_regs_o[MODE_REG*WORD_W +: WORD_W]),
        .syn_pin_i      (lvl[IN_SYN]),
        .drv_pin_i      (lvl[IN_DRV]),
        .pump_sel_o     (pump_sel_o),
        .ref_ext_o      (ref_ext_o),
        .synth_active_o (synth_active_o),
        .ext_lo_sel_o   (ext_lo_sel_o),
        .lo_pins_out_o  (lo_pins_out_o)
    );
endmodule

// File: rtl/serial_cfg_loader_chk.sv
module serial_cfg_loader_chk #(
    parameter int unsigned WORD_W = 24,
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned MODE_R = 5,
    parameter int unsigned SYN_B  = 6
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        load_commit,
    input logic                        sclk_step,
    input logic                        data_bit,
    input logic [WORD_W-1:0]           shift_word,
    input logic [(WORD_W<<ADDR_W)-1:0] cfg_regs_o,
    input logic                        synth_active_o,
    input logic                        lo_pins_out_o
);
    localparam int unsigned NREG = 1 << ADDR_W;

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_regs_o == '0));

    // R5
    no_load_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_commit |=> $stable(cfg_regs_o));

    // R2
    shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_step |=> (shift_word == {$past(shift_word[WORD_W-2:0]), $past(data_bit)}));

    // R9
    pins_need_synth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_pins_out_o |-> synth_active_o);

    // R8
    synth_needs_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        synth_active_o |-> cfg_regs_o[MODE_R*WORD_W + SYN_B]);

    for (genvar g = 0; g < NREG; g++) begin : g_iso
        // R4
        other_reg_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (load_commit && (shift_word[ADDR_W-1:0] != ADDR_W'(g)))
            |=> $stable(cfg_regs_o[g*WORD_W +: WORD_W]));
    end
endmodule

bind serial_cfg_loader serial_cfg_loader_chk #(
    .WORD_W (WORD_W),
    .ADDR_W (ADDR_W),
    .MODE_R (ser_cfg_pkg::MODE_REG),
    .SYN_B  (ser_cfg_pkg::SYN_EN_BIT)
) i_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .load_commit    (load_commit),
    .sclk_step      (sclk_step),
    .data_bit       (lvl[ser_cfg_pkg::IN_SDAT]),
    .shift_word     (shift_word),
    .cfg_regs_o     (cfg_regs_o),
    .synth_active_o (synth_active_o),
    .lo_pins_out_o  (lo_pins_out_o)
);

// File: tb/test_serial_cfg_loader.sv
module test_serial_cfg_loader;
    localparam int W = 24;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0, sdat = 1'b0, sload = 1'b0, syn_pin = 1'b0, drv_pin = 1'b0;
    logic [W*N-1:0] regs;
    logic [1:0] pump;
    logic ref_ext, syn_act, ext_sel, pins_out;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_r [N];

    always #10 clk = ~clk;

    serial_cfg_loader i_serial_cfg_loader (
        .clk(clk), .rst_n(rst_n),
        .ser_clk_i(sclk), .ser_data_i(sdat), .ser_load_i(sload),
        .synth_en_pin_i(syn_pin), .lo_drv_pin_i(drv_pin),
        .cfg_regs_o(regs), .pump_sel_o(pump), .ref_ext_o(ref_ext),
        .synth_active_o(syn_act), .ext_lo_sel_o(ext_sel), .lo_pins_out_o(pins_out)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req);
        for (int i = 0; i < N; i++) chk(req, regs[i*W +: W], exp_r[i]);
    endtask

    task automatic send_bits(input logic [63:0] bits, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) begin
            @(negedge clk); sdat = bits[i];
            repeat (2) @(negedge clk); sclk = 1'b1;
            repeat (3) @(negedge clk); sclk = 1'b0;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic pulse_load();
        @(negedge clk); sload = 1'b1;
        repeat (4) @(negedge clk); sload = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic write_word(input logic [W-1:0] w);
        send_bits({40'd0, w}, W);
        pulse_load();
        exp_r[w[2:0]] = w;
    endtask

    task automatic t_reset();
        for (int i = 0; i < N; i++) exp_r[i] = '0;
        chk_all("R1 regs");
        chk("R1 synth", W'(syn_act), W'(0));
        chk("R1 pins", W'(pins_out), W'(0));
        chk("R1 ext", W'(ext_sel), W'(1));
    endtask

    task automatic t_all_regs();
        for (int i = 0; i < N; i++) begin
            write_word({21'(24'h13579B * (i + 1)), 3'(7 - i)});
            chk_all("R3/R4 write");
        end
    endtask

    task automatic t_no_load();
        send_bits({40'd0, 24'hABCDE2}, W);
        chk_all("R5 shift only");
        @(negedge clk); sload = 1'b1;
        repeat (6) @(negedge clk);
        exp_r[2] = 24'hABCDE2;
        chk_all("R5 load rise");
        send_bits({40'd0, 24'h111112}, W);
        chk_all("R5 load held");
        sload = 1'b0;
        repeat (4) @(negedge clk);
        chk_all("R5 load fall");
    endtask

    task automatic t_extra_bits();
        send_bits({34'd0, 6'b101101, 24'h5A5A51}, 30);
        pulse_load();
        exp_r[1] = 24'h5A5A51;
        chk_all("R6 last 24 bits");
    endtask

    task automatic t_latency();
        send_bits({40'd0, 24'hC0FFE6}, W);
        @(negedge clk); sload = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 after two edges", regs[6*W +: W], exp_r[6]);
        @(negedge clk);
        exp_r[6] = 24'hC0FFE6;
        chk("R10 after three edges", regs[6*W +: W], exp_r[6]);
        @(negedge clk); sload = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_pump();
        for (int c = 0; c < 4; c++) begin
            logic [W-1:0] w;
            w = 24'h0;
            w[11:10] = 2'(c);
            w[18] = c[0];
            w[2:0] = 3'd4;
            write_word(w);
            chk("R7 pump code", W'(pump), W'(c));
            chk("R7 ref source", W'(ref_ext), W'(c[0]));
        end
    endtask

    task automatic t_mode();
        for (int m = 0; m < 16; m++) begin
            logic [W-1:0] w;
            logic ea, eo;
            w = 24'h0;
            w[2:0] = 3'd5;
            w[6] = m[0];
            w[3] = m[1];
            write_word(w);
            @(negedge clk); syn_pin = m[2]; drv_pin = m[3];
            repeat (4) @(negedge clk);
            ea = m[2] & m[0];
            eo = ea & (m[3] | m[1]);
            chk("R8 synth active", W'(syn_act), W'(ea));
            chk("R8 ext route", W'(ext_sel), W'(!ea));
            chk("R9 pin direction", W'(pins_out), W'(eo));
        end
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                repeat (2) @(negedge clk);
                t_reset();
                t_all_regs();
                t_no_load();
                t_extra_bits();
                t_latency();
                t_pump();
                t_mode();
            end
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule